// File: doc/BRIEF.md
# Drift-compensating bit-sliced MVM combiner

This block sits behind the column ADCs of a crossbar that holds each multi-bit weight as a group of binary cells, one column per weight bit. Every stored weight carries a fixed positive offset, so that no cell ever has to hold a negative value. During an inference pass the block receives the digitised column sums one bit slice at a time, most significant slice first. It rebuilds each neuron's product with the input vector by shift-and-add. It does the same for one shared offset column group, whose sum is identical for every neuron, and subtracts that sum to recover the signed pre-activation.

Over time the cells drift and the column currents shrink, which narrows the spread of the results. A separate calibration step reads a column of always-conducting reference cells and latches a gain equal to the nominal reference code divided by the measured code. The gain uses 8 fractional bits, so 256 means unity. Each signed difference is multiplied by this gain, rounded to nearest and saturated to a 12-bit signed word per neuron. The full-scale range is restored without reprogramming any weight.

Top module: `drift_mvm_combiner`

## Requirements
- R1: While rst_ni is low, and until the first result, out_valid_o is 0 and out_data_o is 0. The gain resets to unity (256), so a pass with no prior calibration returns the plain signed difference.
- R2: A pass opens with start_i and accepts WBITS slices (default 4) on slice_valid_i. The first slice accepted is the most significant. Each neuron's sum is the sum over slices of code times 2^(WBITS-1-k), where k is the arrival index 0..WBITS-1. Neuron n reads slice_codes_i bits [n*6+5:n*6].
- R3: The offset sum is built the same way from off_code_i. It is subtracted from every neuron's sum, and all neurons use the same offset.
- R4: A cal_i pulse while idle latches the gain K = floor(REF_NOM*256/c), where c is ref_code_i and REF_NOM defaults to 48. For c = 0, K = 16383, the largest 14-bit value.
- R5: Each result is floor((d*K + 128)/256), where d is the signed difference from R3. This is rounding to nearest, with a half rounding upward.
- R6: Results above 2047 are output as 2047, and results below -2048 are output as -2048. Neuron n drives out_data_o bits [n*12+11:n*12], in two's complement.
- R7: out_valid_o is high for exactly one cycle. It rises on the rising edge that follows the edge accepting the last slice. out_data_o changes only on that edge and holds otherwise.
- R8: A cal_i pulse while a pass is open is ignored. The pass in progress, and later passes, keep the previous gain.
- R9: slice_valid_i while no pass is open is ignored. A start_i during a pass discards the partial sums and restarts the pass. A slice presented in the same cycle as start_i is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_i | input | 1 | Latch a new gain from ref_code_i |
| ref_code_i | input | ADC_W | ADC code of the always-set reference column |
| start_i | input | 1 | Open a pass and clear the partial sums |
| slice_valid_i | input | 1 | A bit slice is present on the code inputs |
| slice_codes_i | input | NEURONS*ADC_W | Column codes of the current slice, one per neuron |
| off_code_i | input | ADC_W | Code of the shared offset column for the current slice |
| out_valid_o | output | 1 | One-cycle pulse marking a new result set |
| out_data_o | output | NEURONS*OUT_W | Saturated signed pre-activations |

## Verification
An accumulator that shifts the wrong way, or that keeps a slice it should have dropped, shows as a wrong word on out_data_o at the very next out_valid_o pulse. That word is off by a power-of-two multiple of the code at fault. A wrong gain register produces results that are scaled wrongly, and the error persists across every later pass until the next idle calibration. A calibration that leaks into an open pass therefore shows in two passes in a row. Counter or control faults show as a missing or double out_valid_o pulse, or as a pulse that arrives a cycle early or late, in the same pass.

// File: rtl/mvmc_pkg.sv
`timescale 1ns/1ps
package mvmc_pkg;
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mvmc_slice_accum.sv
`timescale 1ns/1ps
module mvmc_slice_accum #(
  parameter int ADC_W = 6,
  parameter int ACC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ADC_W-1:0] code_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;

  // MSB slice first: double, then add
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= {acc_q[ACC_W-2:0], 1'b0} + ACC_W'(code_i);
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/mvmc_gain_cal.sv
`timescale 1ns/1ps
module mvmc_gain_cal #(
  parameter int ADC_W   = 6,
  parameter int KFRAC   = 8,
  parameter int REF_NOM = 48,
  parameter int K_W     = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cal_i,
  input  logic             hold_i,
  input  logic [ADC_W-1:0] ref_code_i,
  output logic [K_W-1:0]   k_o
);
  localparam logic [K_W-1:0] K_ONE = K_W'(1 << KFRAC);
  localparam logic [K_W-1:0] K_NUM = K_W'(REF_NOM << KFRAC);
  localparam logic [K_W-1:0] K_MAX = '1;

  logic [K_W-1:0] k_q, k_d, den;

  assign den = K_W'(ref_code_i);

  always_comb begin
    if (ref_code_i == '0) k_d = K_MAX;
    else                  k_d = K_NUM / den;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                k_q <= K_ONE;
    else if (cal_i && !hold_i)  k_q <= k_d;
  end

  assign k_o = k_q;

  assert_gain_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(k_o));
endmodule

// File: rtl/mvmc_scale_sat.sv
`timescale 1ns/1ps
module mvmc_scale_sat #(
  parameter int ACC_W = 10,
  parameter int K_W   = 14,
  parameter int KFRAC = 8,
  parameter int OUT_W = 12
) (
  input  logic [ACC_W-1:0]        acc_i,
  input  logic [ACC_W-1:0]        off_i,
  input  logic [K_W-1:0]          k_i,
  output logic signed [OUT_W-1:0] res_o
);
  localparam int DW = ACC_W + 1;
  localparam int PW = DW + K_W + 1;
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (OUT_W-1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
  localparam logic [PW-1:0]        HALF = PW'(1 << (KFRAC-1));
  localparam logic [K_W-1:0]       K_ONE = K_W'(1 << KFRAC);

  logic signed [DW-1:0]  diff;
  logic signed [K_W:0]   k_s;
  logic signed [PW-1:0]  prod, rnd, sh;
  logic signed [OUT_W-1:0] res;

  always_comb begin
    diff = $signed({1'b0, acc_i}) - $signed({1'b0, off_i});
    k_s  = $signed({1'b0, k_i});
    prod = diff * k_s;
    rnd  = prod + HALF;
    sh   = rnd >>> KFRAC;
    if (sh > MAXV)      res = MAXV[OUT_W-1:0];
    else if (sh < MINV) res = MINV[OUT_W-1:0];
    else                res = sh[OUT_W-1:0];

    if (k_i == K_ONE && PW'(diff) <= MAXV && PW'(diff) >= MINV)
      assert_unity_pass_R5: assert (PW'(res) == PW'(diff));
    if (diff > 0 && k_i != '0)
      assert_sign_keep_R6: assert (res >= 0);
  end

  assign res_o = res;
endmodule

// File: rtl/drift_mvm_combiner.sv
`timescale 1ns/1ps
module drift_mvm_combiner #(
  parameter int NEURONS = 4,
  parameter int ADC_W   = 6,
  parameter int WBITS   = 4,
  parameter int KFRAC   = 8,
  parameter int OUT_W   = 12,
  parameter int REF_NOM = 48
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cal_i,
  input  logic [ADC_W-1:0]           ref_code_i,
  input  logic                       start_i,
  input  logic                       slice_valid_i,
  input  logic [NEURONS*ADC_W-1:0]   slice_codes_i,
  input  logic [ADC_W-1:0]           off_code_i,
  output logic                       out_valid_o,
  output logic [NEURONS*OUT_W-1:0]   out_data_o
);
  import mvmc_pkg::*;

  localparam int ACC_W = ADC_W + WBITS;
  localparam int K_W   = $clog2((REF_NOM << KFRAC) + 1);
  localparam int CW    = cnt_width(WBITS);
  localparam logic [CW-1:0] LAST = CW'(WBITS - 1);

  logic          busy_q, fin_q, valid_q;
  logic [CW-1:0] cnt_q;
  logic          slice_fire;
  logic [K_W-1:0]   k;
  logic [ACC_W-1:0] off_acc;
  logic [ACC_W-1:0] acc   [NEURONS];
  logic [OUT_W-1:0] res   [NEURONS];
  logic [OUT_W-1:0] out_q [NEURONS];

  assign slice_fire = busy_q && slice_valid_i && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= slice_fire && (cnt_q == LAST);
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (slice_fire) begin
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  mvmc_gain_cal #(
    .ADC_W(ADC_W), .KFRAC(KFRAC), .REF_NOM(REF_NOM), .K_W(K_W)
  ) u_gain (
    .clk_i(clk_i), .rst_ni(rst_ni), .cal_i(cal_i), .hold_i(busy_q),
    .ref_code_i(ref_code_i), .k_o(k)
  );

  mvmc_slice_accum #(.ADC_W(ADC_W), .ACC_W(ACC_W)) u_off_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_i), .en_i(slice_fire),
    .code_i(off_code_i), .acc_o(off_acc)
  );

  for (genvar n = 0; n < NEURONS; n++) begin : g_neuron
    mvmc_slice_accum #(.ADC_W(ADC_W), .ACC_W(ACC_W)) u_acc (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_i), .en_i(slice_fire),
      .code_i(slice_codes_i[n*ADC_W +: ADC_W]), .acc_o(acc[n])
    );
    mvmc_scale_sat #(
      .ACC_W(ACC_W), .K_W(K_W), .KFRAC(KFRAC), .OUT_W(OUT_W)
    ) u_scale (
      .acc_i(acc[n]), .off_i(off_acc), .k_i(k), .res_o(res[n])
    );
    assign out_data_o[n*OUT_W +: OUT_W] = out_q[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      for (int n = 0; n < NEURONS; n++) out_q[n] <= '0;
    end else begin
      valid_q <= fin_q;
      if (fin_q) for (int n = 0; n < NEURONS; n++) out_q[n] <= res[n];
    end
  end

  assign out_valid_o = valid_q;

  assert_one_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  assert_valid_after_slice_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(slice_fire, 2));
  assert_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_data_o));
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (int'(cnt_q) < WBITS));
endmodule

// File: tb/drift_mvm_combiner_tb.sv
`timescale 1ns/1ps
module drift_mvm_combiner_tb;
  localparam int N  = 4;
  localparam int AW = 6;
  localparam int WB = 4;
  localparam int OW = 12;
  localparam int RN = 48;

  // table: {ref code, seed}
  localparam logic [11:0] VEC [6] = '{
    {6'd48, 6'd3}, {6'd24, 6'd11}, {6'd36, 6'd17},
    {6'd60, 6'd22}, {6'd12, 6'd40}, {6'd63, 6'd55}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal = 1'b0, start = 1'b0, slv = 1'b0;
  logic [AW-1:0] ref_code = '0, off_code = '0;
  logic [N*AW-1:0] codes = '0;
  logic out_valid;
  logic [N*OW-1:0] out_data;

  int tests = 0, fails = 0;
  int model_k = 256;
  logic [AW-1:0] cd [WB][N+1];

  always #2.5 clk = ~clk;

  drift_mvm_combiner u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cal_i(cal), .ref_code_i(ref_code),
    .start_i(start), .slice_valid_i(slv), .slice_codes_i(codes),
    .off_code_i(off_code), .out_valid_o(out_valid), .out_data_o(out_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int outn(input int n);
    return int'($signed(out_data[n*OW +: OW]));
  endfunction

  function automatic int expect_val(input int d);
    longint p;
    p = longint'(d) * longint'(model_k) + 128;
    p = p >>> 8;
    if (p > 2047) p = 2047;
    if (p < -2048) p = -2048;
    return int'(p);
  endfunction

  task automatic fill_seed(input int seed);
    for (int s = 0; s < WB; s++)
      for (int n = 0; n <= N; n++)
        cd[s][n] = AW'((seed*7 + s*13 + n*29 + seed*s*n*3 + seed*seed) % 64);
  endtask

  task automatic fill_const(input int v);
    for (int s = 0; s < WB; s++)
      for (int n = 0; n <= N; n++) cd[s][n] = AW'(v);
  endtask

  task automatic do_cal(input int c);
    @(negedge clk); cal = 1'b1; ref_code = AW'(c);
    @(negedge clk); cal = 1'b0;
    model_k = (c == 0) ? 16383 : (RN * 256) / c;
  endtask

  task automatic drive_slice(input int s);
    slv = 1'b1;
    for (int n = 0; n < N; n++) codes[n*AW +: AW] = cd[s][n];
    off_code = cd[s][N];
  endtask

  // mode 0 normal, 1 restart mid-pass, 2 slice coincident with start, 3 cal mid-pass
  task automatic run_pass(input string tag, input int mode);
    int acc [N+1];
    @(negedge clk); start = 1'b1;
    if (mode == 2) begin
      slv = 1'b1; codes = '1; off_code = '0;
    end
    @(negedge clk); start = 1'b0; slv = 1'b0;
    if (mode == 1) begin
      slv = 1'b1; codes = '1; off_code = 6'd5;
      @(negedge clk); @(negedge clk);
      slv = 1'b0; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int s = 0; s < WB; s++) begin
      drive_slice(s);
      if (mode == 3) begin
        cal = (s == 1); ref_code = 6'd12;
      end
      @(negedge clk);
    end
    slv = 1'b0; cal = 1'b0;
    check({tag, " R7 no early valid"}, int'(out_valid), 0);
    @(negedge clk);
    check({tag, " R7 valid pulse"}, int'(out_valid), 1);
    for (int n = 0; n <= N; n++) begin
      acc[n] = 0;
      for (int s = 0; s < WB; s++) acc[n] += int'(cd[s][n]) << (WB-1-s);
    end
    for (int n = 0; n < N; n++)
      check($sformatf("%s R2 R3 R5 R6 neuron %0d", tag, n), outn(n),
            expect_val(acc[n] - acc[N]));
    @(negedge clk);
    check({tag, " R7 single pulse"}, int'(out_valid), 0);
    check({tag, " R7 data hold"}, outn(0), expect_val(acc[0] - acc[N]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset data", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset valid", int'(out_valid), 0);

    // R1/R2: unity gain, hand-built slice order
    fill_const(0);
    cd[0][0] = 6'd1;        // MSB slice -> 8
    cd[3][1] = 6'd1;        // LSB slice -> 1
    cd[1][2] = 6'd2;        // 2*4 = 8
    cd[3][N] = 6'd1;        // offset 1
    run_pass("R1 unity", 0);
    check("R2 msb weight n0", outn(0), 7);
    check("R3 offset n3", outn(3), -1);

    // table walk, R4 gains
    for (int i = 0; i < 6; i++) begin
      do_cal(int'(VEC[i][11:6]));
      fill_seed(int'(VEC[i][5:0]));
      run_pass($sformatf("R4 vec%0d", i), 0);
    end

    // R6 saturation with K max (R4 zero code)
    do_cal(0);
    fill_const(0);
    for (int s = 0; s < WB; s++) cd[s][0] = 6'd63;
    run_pass("R6 pos", 0);
    check("R6 pos sat", outn(0), 2047);
    fill_const(63);
    for (int s = 0; s < WB; s++) cd[s][0] = 6'd0;
    run_pass("R6 neg", 0);
    check("R6 neg sat", outn(0), -2048);
    check("R6 zero diff", outn(1), 0);

    // R5 rounding, K = 341
    do_cal(36);
    fill_const(0);
    cd[3][0] = 6'd3; cd[3][1] = 6'd1; cd[3][N] = 6'd0;
    cd[2][2] = 6'd0; cd[3][3] = 6'd0;
    run_pass("R5 round", 0);
    check("R5 round +3", outn(0), 4);
    check("R5 round +1", outn(1), 1);

    // R8 calibration ignored during a pass
    do_cal(48);
    fill_seed(9);
    run_pass("R8 cal mid-pass", 3);
    run_pass("R8 after pass", 0);

    // R9 idle slice ignored
    @(negedge clk); slv = 1'b1; codes = '1; off_code = 6'd7;
    @(negedge clk); slv = 1'b0;
    @(negedge clk);
    check("R9 idle slice no valid", int'(out_valid), 0);
    @(negedge clk);
    check("R9 idle slice no valid 2", int'(out_valid), 0);
    fill_seed(30);
    run_pass("R9 after idle slice", 0);
    run_pass("R9 restart", 1);
    run_pass("R9 start drops slice", 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule